// File: doc/BRIEF.md
# Tiled Aperture Fence Bank

This block keeps a bank of sixteen range registers that sit over a linear graphics aperture. Each register describes one window: where the window starts, the last 4 KiB page it covers, the surface stride, and whether the surface inside is laid out in X tiles or Y tiles. For every CPU access to the aperture, the block looks for a live register whose window holds the address. If it finds one, it returns the address moved into tiled memory order. If it finds none, the address passes through unchanged.

Software programs each 64-bit entry as two 32-bit words. To change a live entry safely, it first clears the low word, which drops the valid bit. It then writes the high word, and writes the low word with valid set as the last step. A small guard backs this up. Any write to the high word parks the entry until its low word is written again, so a half-updated window never takes part in matching. Both words read back exactly as they were written, so a posting read can confirm each step.

Top module: `fence_bank`

## Requirements
- R1: After reset, every register word reads back as zero, and no access hits. `rsp_valid_o` stays low until an access is presented.
- R2: A read of either word of any entry returns the last value written to that word, unchanged by the guard.
- R3: The cfg address selects the entry with bits [4:1] and the word with bit 0 (0 = low, 1 = high). The low word holds the start page in bits [31:12], Y tiling in bit 1 (clear means X tiling) and valid in bit 0. The high word holds the last page in bits [31:12] and the pitch in bits [9:0], where pitch = stride/128 - 1.
- R4: An entry whose low word has the valid bit clear never hits.
- R5: A write to an entry's high word takes that entry out of matching until its low word is written again. The entry then takes part again if the newly written valid bit is set.
- R6: The window starts at start page × 4096. Let size = (last - start + 1) × 4096, or zero when last < start, and let row = stride × 8 for X tiling or stride × 32 for Y tiling. The window then holds exactly floor(size/row) × row bytes.
- R7: When several live windows hold the address, the lowest-numbered entry wins.
- R8: A miss returns the input address unchanged, with hit low and fence index zero.
- R9: X tiling uses 512-byte × 8-row tiles of 4 KiB, and stride must be a multiple of 512. Let offset o = address - base, y = o / stride and x = o % stride. The result is base + (y/8)·stride·8 + (x/512)·4096 + (y%8)·512 + x%512.
- R10: Y tiling uses 128-byte × 32-row tiles made of 16-byte columns. The result is base + (y/32)·stride·32 + (x/128)·4096 + ((x%128)/16)·512 + (y%32)·16 + x%16.
- R11: The result of an access presented in cycle t is on the outputs in cycle t+1. `rsp_valid_o` is high in exactly the cycles that follow a cycle with `req_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Entry index [4:1] and word select [0] |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Current content of the addressed word (combinational) |
| req_valid_i | input | 1 | Aperture access present |
| req_addr_i | input | 32 | Linear aperture address |
| rsp_valid_o | output | 1 | Result valid, one cycle after the access |
| rsp_hit_o | output | 1 | A live window held the address |
| rsp_fence_o | output | 4 | Index of the winning entry, zero on a miss |
| rsp_addr_o | output | 32 | Tiled address on a hit, input address on a miss |

## Verification
A register write takes effect at the clock edge that samples it. A read of the same word shows the new value after that edge, and an access presented from the next cycle on sees the new window. Each access result is registered once, so the bench drives the request at a falling edge and samples all four response outputs at the next falling edge. It then samples `rsp_valid_o` one cycle later to confirm the response has dropped. Readbacks are checked a short delay after the address is set in a cycle with no write, since the read path has no register.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned PAGE_LSB  = 12;
  localparam int unsigned PAGE_W    = WORD_W - PAGE_LSB;
  localparam int unsigned VALID_BIT = 0;
  localparam int unsigned YTILE_BIT = 1;
  localparam int unsigned LIM_W     = WORD_W + 1;

  typedef enum logic {
    TILE_X = 1'b0,
    TILE_Y = 1'b1
  } tile_e;

  // log2 of rows per tile times 128-byte units
  function automatic int unsigned row_shift(tile_e m);
    return (m == TILE_Y) ? 12 : 10;
  endfunction
endpackage

// File: rtl/fence_regfile.sv
module fence_regfile
  import fence_pkg::*;
#(
  parameter int unsigned N_FENCE = 16,
  parameter int unsigned PITCH_W = 10,
  localparam int unsigned IDX_W  = $clog2(N_FENCE)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W:0]      addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [PAGE_W-1:0]   base_pg_o [N_FENCE],
  output logic [PITCH_W-1:0]  pitch_o   [N_FENCE],
  output logic                ytile_o   [N_FENCE],
  output logic [LIM_W-1:0]    lim_o     [N_FENCE],
  output logic [N_FENCE-1:0]  act_o
);
  logic [WORD_W-1:0] lo_q [N_FENCE];
  logic [WORD_W-1:0] hi_q [N_FENCE];
  logic [LIM_W-1:0]  lim_q [N_FENCE];
  logic [N_FENCE-1:0] armed_q;

  logic [IDX_W-1:0] widx;
  logic             whi;
  assign widx = addr_i[IDX_W:1];
  assign whi  = addr_i[0];

  // fields as they stand after this cycle's write
  logic [PAGE_W-1:0]  st_pg_n, last_pg_n;
  logic [PITCH_W-1:0] pitch_n;
  tile_e              mode_n;
  logic [PAGE_W:0]    npg;
  logic [LIM_W-1:0]   size_b, row_b, lim_n;

  always_comb begin
    st_pg_n   = (we_i && !whi) ? wdata_i[WORD_W-1:PAGE_LSB] : lo_q[widx][WORD_W-1:PAGE_LSB];
    mode_n    = tile_e'((we_i && !whi) ? wdata_i[YTILE_BIT] : lo_q[widx][YTILE_BIT]);
    last_pg_n = (we_i && whi) ? wdata_i[WORD_W-1:PAGE_LSB] : hi_q[widx][WORD_W-1:PAGE_LSB];
    pitch_n   = (we_i && whi) ? wdata_i[PITCH_W-1:0] : hi_q[widx][PITCH_W-1:0];
    npg       = {1'b0, last_pg_n} - {1'b0, st_pg_n} + (PAGE_W+1)'(1);
    size_b    = (last_pg_n >= st_pg_n) ? {npg, {PAGE_LSB{1'b0}}} : '0;
    row_b     = (LIM_W'(pitch_n) + LIM_W'(1)) << row_shift(mode_n);
    lim_n     = size_b - (size_b % row_b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= '0;
      for (int i = 0; i < N_FENCE; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        lim_q[i] <= '0;
      end
    end else if (we_i) begin
      if (whi) begin
        hi_q[widx]    <= wdata_i;
        armed_q[widx] <= 1'b0;
      end else begin
        lo_q[widx]    <= wdata_i;
        armed_q[widx] <= 1'b1;
      end
      lim_q[widx] <= lim_n;
    end
  end

  assign rdata_o = whi ? hi_q[widx] : lo_q[widx];

  for (genvar g = 0; g < N_FENCE; g++) begin : g_out
    assign base_pg_o[g] = lo_q[g][WORD_W-1:PAGE_LSB];
    assign pitch_o[g]   = hi_q[g][PITCH_W-1:0];
    assign ytile_o[g]   = lo_q[g][YTILE_BIT];
    assign lim_o[g]     = lim_q[g];
    assign act_o[g]     = lo_q[g][VALID_BIT] & armed_q[g];
  end
endmodule

// File: rtl/fence_match.sv
module fence_match
  import fence_pkg::*;
#(
  parameter int unsigned N_FENCE = 16,
  localparam int unsigned IDX_W  = $clog2(N_FENCE)
) (
  input  logic [WORD_W-1:0]  addr_i,
  input  logic [PAGE_W-1:0]  base_pg_i [N_FENCE],
  input  logic [LIM_W-1:0]   lim_i     [N_FENCE],
  input  logic [N_FENCE-1:0] act_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [N_FENCE-1:0] in_win;

  for (genvar g = 0; g < N_FENCE; g++) begin : g_cmp
    logic [WORD_W-1:0] base_b;
    logic [LIM_W-1:0]  off_b;
    assign base_b    = {base_pg_i[g], {PAGE_LSB{1'b0}}};
    assign off_b     = {1'b0, addr_i} - {1'b0, base_b};
    assign in_win[g] = act_i[g] && (addr_i >= base_b) && (off_b < lim_i[g]);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_FENCE - 1; i >= 0; i--) begin
      if (in_win[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |in_win;
endmodule

// File: rtl/fence_remap.sv
module fence_remap
  import fence_pkg::*;
#(
  parameter int unsigned PITCH_W = 10
) (
  input  logic [WORD_W-1:0]  off_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  tile_e              mode_i,
  output logic [WORD_W-1:0]  toff_o
);
  logic [WORD_W-1:0] stride, y, x;
  logic [WORD_W-1:0] t_x, t_y;

  always_comb begin
    stride = (WORD_W'(pitch_i) + WORD_W'(1)) << 7;
    y      = off_i / stride;
    x      = off_i - y * stride;
    t_x    = (((y >> 3) * stride) << 3) + ((x >> 9) << 12)
           + ((y & 32'd7) << 9) + (x & 32'd511);
    t_y    = (((y >> 5) * stride) << 5) + ((x >> 7) << 12)
           + (((x >> 4) & 32'd7) << 9) + ((y & 32'd31) << 4) + (x & 32'd15);
    toff_o = (mode_i == TILE_Y) ? t_y : t_x;
  end
endmodule

// File: rtl/fence_bank.sv
module fence_bank
  import fence_pkg::*;
#(
  parameter int unsigned N_FENCE = 16,
  parameter int unsigned PITCH_W = 10,
  localparam int unsigned IDX_W  = $clog2(N_FENCE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W:0]    cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_fence_o,
  output logic [31:0]       rsp_addr_o
);
  logic [PAGE_W-1:0]  base_pg [N_FENCE];
  logic [PITCH_W-1:0] pitch   [N_FENCE];
  logic               ytile   [N_FENCE];
  logic [LIM_W-1:0]   lim     [N_FENCE];
  logic [N_FENCE-1:0] fence_act;

  fence_regfile #(.N_FENCE(N_FENCE), .PITCH_W(PITCH_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .base_pg_o(base_pg), .pitch_o(pitch), .ytile_o(ytile), .lim_o(lim), .act_o(fence_act)
  );

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;

  fence_match #(.N_FENCE(N_FENCE)) u_match (
    .addr_i(req_addr_i), .base_pg_i(base_pg), .lim_i(lim), .act_i(fence_act),
    .hit_o(m_hit), .idx_o(m_idx)
  );

  logic [WORD_W-1:0] base_sel, toff;
  assign base_sel = {base_pg[m_idx], {PAGE_LSB{1'b0}}};

  fence_remap #(.PITCH_W(PITCH_W)) u_remap (
    .off_i(req_addr_i - base_sel), .pitch_i(pitch[m_idx]),
    .mode_i(tile_e'(ytile[m_idx])), .toff_o(toff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fence_o <= '0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o   <= m_hit;
        rsp_fence_o <= m_hit ? m_idx : '0;
        rsp_addr_o  <= m_hit ? (base_sel + toff) : req_addr_i;
      end
    end
  end
endmodule

// File: rtl/fence_bank_chk.sv
module fence_bank_chk #(
  parameter int unsigned N_FENCE = 16,
  localparam int unsigned IDX_W  = $clog2(N_FENCE)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [IDX_W:0]     cfg_addr_i,
  input logic [31:0]        cfg_wdata_i,
  input logic [31:0]        cfg_rdata_o,
  input logic               req_valid_i,
  input logic [31:0]        req_addr_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic [IDX_W-1:0]   rsp_fence_o,
  input logic [31:0]        rsp_addr_o,
  input logic [N_FENCE-1:0] act_i
);
  logic [IDX_W-1:0]   last_idx_q;
  logic [N_FENCE-1:0] act_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_idx_q <= '0;
      act_prev_q <= '0;
    end else begin
      last_idx_q <= cfg_addr_i[IDX_W:1];
      act_prev_q <= act_i;
    end
  end

  AST_RDBACK_LAST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_addr_i != $past(cfg_addr_i) || cfg_rdata_o == $past(cfg_wdata_i))); // R2
  AST_HIT_NEEDS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> act_prev_q[rsp_fence_o]); // R4
  AST_HIGH_WRITE_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i[0]) |=> !act_i[last_idx_q]); // R5
  AST_MISS_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_hit_o || (rsp_addr_o == $past(req_addr_i) && rsp_fence_o == '0))); // R8
  AST_CHUNK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_addr_o[3:0] == $past(req_addr_i[3:0])); // R9 R10
  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R11
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R11
endmodule

bind fence_bank fence_bank_chk #(.N_FENCE(N_FENCE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .req_valid_i(req_valid_i),
  .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
  .rsp_fence_o(rsp_fence_o), .rsp_addr_o(rsp_addr_o), .act_i(fence_act)
);

// File: tb/sim_fence_bank.sv
`timescale 1ns/1ps
module sim_fence_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_fence;
  logic [31:0] rsp_addr;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  bit          m_arm [16];

  always #2 clk = ~clk;

  fence_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_fence_o(rsp_fence), .rsp_addr_o(rsp_addr)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected result from the requirements
  function automatic void model(input logic [31:0] a, output bit h, output int idx,
                                output logic [31:0] t);
    h = 0; idx = 0; t = a;
    for (int i = 0; i < 16; i++) begin
      longint unsigned st, la, size, row, lim, base, o, s, y, x, r;
      if (!(m_lo[i][0] && m_arm[i])) continue;
      st = m_lo[i][31:12]; la = m_hi[i][31:12];
      size = (la >= st) ? (la - st + 1) * 4096 : 0;
      s = (longint'(m_hi[i][9:0]) + 1) * 128;
      row = s * (m_lo[i][1] ? 32 : 8);
      lim = size - size % row;
      base = st * 4096;
      if (a < base || (a - base) >= lim) continue;
      o = a - base; y = o / s; x = o % s;
      if (m_lo[i][1])
        r = (y/32)*s*32 + (x/128)*4096 + ((x%128)/16)*512 + (y%32)*16 + x%16;
      else
        r = (y/8)*s*8 + (x/512)*4096 + (y%8)*512 + x%512;
      h = 1; idx = i; t = 32'(base + r);
      return;
    end
  endfunction

  task automatic wr(int idx, bit half, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {idx[3:0], half}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (half) begin m_hi[idx] = d; m_arm[idx] = 0; end
    else begin m_lo[idx] = d; m_arm[idx] = 1; end
  endtask

  task automatic rd_chk(int idx, bit half, string req);
    logic [31:0] e;
    @(negedge clk);
    cfg_addr = {idx[3:0], half};
    #1;
    e = half ? m_hi[idx] : m_lo[idx];
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic acc(logic [31:0] a, string req);
    bit h; int idx; logic [31:0] t;
    model(a, h, idx, t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " R11 valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == h, {req, " hit"}, 32'(rsp_hit), 32'(h));
    chk(rsp_fence == 4'(idx), {req, " fence"}, 32'(rsp_fence), 32'(idx));
    chk(rsp_addr == t, {req, " addr"}, rsp_addr, t);
  endtask

  task automatic prog(int idx, logic [19:0] st, int npg, logic [9:0] p, bit y, bit v);
    logic [19:0] la;
    la = st + 20'(npg - 1);
    wr(idx, 0, 32'd0);
    wr(idx, 1, {la, 2'b00, p});
    wr(idx, 0, {st, 10'd0, y, v});
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_arm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 16; i++) begin
      rd_chk(i, 0, "R1 low reset");
      rd_chk(i, 1, "R1 high reset");
    end
    acc(32'h0000_1234, "R1 R8 miss after reset");

    // X tiling, stride 512
    prog(0, 20'h00100, 4, 10'd3, 0, 1);
    rd_chk(0, 0, "R2 R3 low readback");
    rd_chk(0, 1, "R2 R3 high readback");
    acc(32'h0010_0000, "R9 X base");
    acc(32'h0010_0205, "R9 X second row");
    acc(32'h0010_1FF3, "R9 X tile edge");
    acc(32'h0010_3FFF, "R6 X last byte");
    acc(32'h0010_4000, "R6 X past end");

    // Y tiling, stride 384: row 12288, window of 4 pages trimmed to 12288
    prog(5, 20'h00200, 4, 10'd2, 1, 1);
    acc(32'h0020_0000, "R10 Y base");
    acc(32'h0020_0093, "R10 Y chunk");
    acc(32'h0020_2FFF, "R6 Y last kept byte");
    acc(32'h0020_3000, "R6 Y trimmed tail");

    // overlap: entry 3 beats entry 7
    prog(7, 20'h00300, 16, 10'd7, 0, 1);
    prog(3, 20'h00300, 8, 10'd1, 1, 1);
    acc(32'h0030_0444, "R7 overlap low index");
    acc(32'h0030_9444, "R7 only higher entry");

    // guard: high-only write parks entry 3
    wr(3, 1, {20'h00307, 2'b00, 10'd3});
    rd_chk(3, 1, "R2 high after guard");
    rd_chk(3, 0, "R2 low unchanged by guard");
    acc(32'h0030_0444, "R5 parked entry skipped");
    wr(3, 0, {20'h00300, 10'd0, 1'b0, 1'b1});
    acc(32'h0030_0444, "R5 entry back after low write");

    // valid clear never hits
    wr(7, 0, {20'h00300, 10'd0, 1'b0, 1'b0});
    rd_chk(7, 0, "R2 low with valid clear");
    acc(32'h0030_9444, "R4 invalid entry");
    acc(32'hFFFF_FFF0, "R8 far miss");

    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 idle after response", 32'(rsp_valid), 32'd0);

    // random phase
    for (int round = 0; round < 6; round++) begin
      for (int k = 0; k < 4; k++) begin
        int idx; bit y; logic [9:0] p; logic [19:0] st; int npg;
        idx = $urandom_range(15, 0);
        y   = 1'($urandom_range(1, 0));
        p   = y ? 10'($urandom_range(63, 0)) : 10'(4 * $urandom_range(16, 1) - 1);
        st  = 20'($urandom_range(32'hFFF00, 0));
        npg = $urandom_range(128, 1);
        prog(idx, st, npg, p, y, ($urandom_range(9, 0) != 0));
        rd_chk(idx, 1, "R2 random high");
      end
      for (int n = 0; n < 60; n++) begin
        int f; logic [31:0] a;
        f = $urandom_range(15, 0);
        if ($urandom_range(9, 0) < 7 && m_lo[f][0])
          a = {m_lo[f][31:12], 12'd0} + 32'($urandom_range(32'h7FFFF, 0));
        else
          a = $urandom();
        acc(a, m_lo[f][1] ? "R10 R6 random" : "R9 R6 random");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule